// File: doc/BRIEF.md
# Systolic Matrix Multiplier

This block multiplies two square N×N matrices of signed integers on a grid of N×N multiply-accumulate cells. After a start pulse it takes one matrix slice per cycle for N cycles. On the top edge it takes one row of B, and on the left edge it takes one column of A. Internal delay lines skew these slices so that each operand pair meets in the correct cell. B values move down the grid and A values move right, one register stage per cell. Once the real operands run out, zeros are fed in so that the trailing cells can finish without their sums being disturbed.

When the compute window ends, every cell holds one finished element of C = A × B. The grid then moves its results upward one row per cycle and presents the top row at the output, so the rows of C emerge in order from row 0. A done flag marks the end of the unload and stays high until the next start.

Top module: `sysmm_array`

## Requirements
- R1: While reset is held and in the first cycle after it, `res_valid` and `done` are low.
- R2: `start` is accepted only when idle or done. The edge that accepts it is followed by cycle k = 0..N-1, in which the block samples column k of A on `a_col` (A[r][k] at bits [r*DW +: DW]) and row k of B on `b_row` (B[k][c] at bits [c*DW +: DW]). The block ignores the values on these ports in every other cycle.
- R3: `res_valid` first goes high in cycle 3N-2, counted in the same way, and so after exactly 3N-2 compute cycles.
- R4: `res_valid` stays high for exactly N consecutive cycles. In the s-th of these cycles `res_row` carries row s of C, with C[s][c] at bits [c*AW +: AW] in two's complement, where AW = 2*DW + clog2(N).
- R5: Every element equals the exact signed sum of products, including the case where all operands are -2^(DW-1). In that case the sum exceeds the 2*DW-bit range.
- R6: `done` rises in the cycle after the last result row and stays high until the next accepted start. That start drops it and clears every accumulator, so a new product does not depend on the previous one.
- R7: A `start` pulse during the compute phase is ignored. It neither restarts the operation nor shifts the timing of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication |
| a_col | input | N*DW | One column of A, element r in slice r |
| b_row | input | N*DW | One row of B, element c in slice c |
| res_row | output | N*AW | One row of C, element c in slice c |
| res_valid | output | 1 | `res_row` holds a result row |
| done | output | 1 | All rows of C have been unloaded |

## Verification
The bench builds the block with N=4 and DW=8. This gives skew depths 0 to 3, a ten-cycle compute window and an 18-bit result field. With these values, an all -128 product reaches 65536, which a 16-bit product word cannot hold. The bench fills the input ports with non-zero values outside the feed window and pulses start in the middle of the compute phase. Both show at the outputs whether the zero padding and the busy guard work. Back-to-back runs show whether the accumulators are cleared between runs.

// File: rtl/sysmm_array.sv
module sysmm_array #(
  parameter int N  = 4,
  parameter int DW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [N*DW-1:0]              a_col,
  input  logic [N*DW-1:0]              b_row,
  output logic [N*(2*DW+$clog2(N))-1:0] res_row,
  output logic                         res_valid,
  output logic                         done
);
  localparam int AW = 2*DW + $clog2(N);
  localparam int CW = $clog2(3*N);
  localparam logic [CW-1:0] NC      = CW'(N);
  localparam logic [CW-1:0] LAST_RUN = CW'(3*N-3);
  localparam logic [CW-1:0] LAST_SH  = CW'(N-1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_SHIFT, S_DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic feeding, accept;
  logic [N*DW-1:0] feed_a, feed_b, edge_a, edge_b;
  logic signed [DW-1:0] a_in [N][N];
  logic signed [DW-1:0] b_in [N][N];
  logic signed [DW-1:0] a_pipe [N][N-1];
  logic signed [DW-1:0] b_pipe [N-1][N];
  logic signed [AW-1:0] acc [N][N];

  assign feeding   = (st == S_RUN) && (cnt < NC);
  assign accept    = start && (st == S_IDLE || st == S_DONE);
  assign feed_a    = feeding ? a_col : '0;
  assign feed_b    = feeding ? b_row : '0;
  assign res_valid = (st == S_SHIFT);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_RUN: begin
          if (cnt == LAST_RUN) begin st <= S_SHIFT; cnt <= '0; end
          else cnt <= cnt + CW'(1);
        end
        S_SHIFT: begin
          if (cnt == LAST_SH) st <= S_DONE;
          else cnt <= cnt + CW'(1);
        end
        default: if (accept) begin st <= S_RUN; cnt <= '0; end
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_skew
    if (i == 0) begin : g_direct
      assign edge_a[DW-1:0] = feed_a[DW-1:0];
      assign edge_b[DW-1:0] = feed_b[DW-1:0];
    end else begin : g_delay
      logic [DW-1:0] la [i];
      logic [DW-1:0] lb [i];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int d = 0; d < i; d++) begin la[d] <= '0; lb[d] <= '0; end
        end else begin
          la[0] <= feed_a[i*DW +: DW];
          lb[0] <= feed_b[i*DW +: DW];
          for (int d = 1; d < i; d++) begin la[d] <= la[d-1]; lb[d] <= lb[d-1]; end
        end
      end
      assign edge_a[i*DW +: DW] = la[i-1];
      assign edge_b[i*DW +: DW] = lb[i-1];
    end
    assign res_row[i*AW +: AW] = acc[0][i];
  end

  always_comb begin
    for (int r = 0; r < N; r++) begin
      a_in[r][0] = edge_a[r*DW +: DW];
      for (int c = 1; c < N; c++) a_in[r][c] = a_pipe[r][c-1];
    end
    for (int c = 0; c < N; c++) begin
      b_in[0][c] = edge_b[c*DW +: DW];
      for (int r = 1; r < N; r++) b_in[r][c] = b_pipe[r-1][c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          acc[r][c] <= '0;
          if (c < N-1) a_pipe[r][c] <= '0;
          if (r < N-1) b_pipe[r][c] <= '0;
        end
    end else begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          logic signed [2*DW-1:0] prod;
          prod = a_in[r][c] * b_in[r][c];
          if (c < N-1) a_pipe[r][c] <= a_in[r][c];
          if (r < N-1) b_pipe[r][c] <= b_in[r][c];
          if (accept)
            acc[r][c] <= '0;
          else if (st == S_RUN)
            acc[r][c] <= acc[r][c] + {{(AW-2*DW){prod[2*DW-1]}}, prod};
          else if (st == S_SHIFT)
            acc[r][c] <= (r == N-1) ? '0 : acc[(r+1)%N][c];
        end
    end
  end

  // R3
  first_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> ($past(st) == S_RUN && $past(cnt) == LAST_RUN));

  // R6
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(res_valid));

  // R4
  valid_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(res_valid) |-> done);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && start && cnt != LAST_RUN) |=> (st == S_RUN && cnt == $past(cnt) + CW'(1)));
endmodule

// File: tb/test_sysmm_array.sv
`timescale 1ns/1ps
module test_sysmm_array;
  localparam int N  = 4;
  localparam int DW = 8;
  localparam int AW = 2*DW + $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N*DW-1:0] a_col = '0;
  logic [N*DW-1:0] b_row = '0;
  logic [N*AW-1:0] res_row;
  logic res_valid, done;

  int total = 0;
  int bad = 0;
  int ma [N][N];
  int mb [N][N];

  always #2.5 clk = ~clk;

  sysmm_array #(.N(N), .DW(DW)) i_sysmm_array (
    .clk(clk), .rst_n(rst_n), .start(start), .a_col(a_col), .b_row(b_row),
    .res_row(res_row), .res_valid(res_valid), .done(done));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_mult(input string name, input bit busy_poke);
    int first_v = -1;
    int nrows = 0;
    int done_at = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int cyc = 0; cyc < 5*N; cyc++) begin
      if (cyc > 0) @(negedge clk);
      if (cyc == 0) check({name, " R6 done cleared by start"}, int'(done), 0);
      if (res_valid) begin
        if (first_v < 0) first_v = cyc;
        if (cyc - first_v == nrows && nrows < N) begin
          for (int c = 0; c < N; c++) begin
            int e = 0;
            for (int k = 0; k < N; k++) e += ma[nrows][k] * mb[k][c];
            check({name, " R4 R5 element"}, int'($signed(res_row[c*AW +: AW])), e);
          end
        end
        nrows++;
      end
      if (done && done_at < 0) done_at = cyc;
      start = busy_poke && (cyc == N + 1);
      for (int i = 0; i < N; i++) begin
        if (cyc < N) begin
          a_col[i*DW +: DW] = DW'(ma[i][cyc]);
          b_row[i*DW +: DW] = DW'(mb[cyc][i]);
        end else begin
          a_col[i*DW +: DW] = DW'(37 + 11*i + cyc);
          b_row[i*DW +: DW] = DW'(-53 + 7*i - cyc);
        end
      end
    end
    start = 1'b0;
    check({name, " R3 first row cycle"}, first_v, 3*N-2);
    check({name, " R4 row count"}, nrows, N);
    check({name, " R6 done cycle"}, done_at, 4*N-2);
    @(negedge clk);
    check({name, " R6 done held"}, int'(done), 1);
    check({name, " R2 idle inputs ignored"}, int'(res_valid), 0);
  endtask

  task automatic t_identity();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r == c) ? 1 : 0;
        mb[r][c] = r*N + c - 7;
      end
    run_mult("identity", 1'b0);
  endtask

  task automatic t_random(input int seed);
    void'($urandom(seed));
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = int'($urandom_range(255, 0)) - 128;
        mb[r][c] = int'($urandom_range(255, 0)) - 128;
      end
    run_mult("random", 1'b0);
  endtask

  task automatic t_extreme();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = -128;
        mb[r][c] = ((r + c) % 2 == 0) ? -128 : 127;
      end
    run_mult("extreme_mix", 1'b0);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) mb[r][c] = -128;
    run_mult("extreme_max", 1'b0);
  endtask

  task automatic t_busy_start();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = r - c + 3;
        mb[r][c] = 2*c - r;
      end
    run_mult("busy_start R7", 1'b1);
  endtask

  initial begin
    #4000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(res_valid), 0);
    check("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(res_valid), 0);
    check("R1 done after reset", int'(done), 0);
    t_identity();
    t_random(11);
    t_random(4242);
    t_extreme();
    t_busy_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule